// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between the clock generators of a desktop clock chip and its output pins. It gates seven groups of running clocks: processor, PCI, free-running PCI, graphics port (AGP), SDRAM, USB and reference. Three active-low power management requests and a mode strap decide which groups are gated. Every output is parked low when stopped. Each group's request is resynchronised on the falling edges of that group's own clock, so a gate opens or closes only while the clock is low. No output pulse is ever clipped.

The requests form three nested stop domains. A processor stop parks only the processor outputs. A PCI stop parks the ordinary PCI outputs, but the free-running PCI output and the AGP outputs keep toggling. A power-down overrides everything: all groups are parked and the oscillator and PLL enables drop. A small sequencer on the reference clock tracks power-down. Its states are `PS_RUN` (clocks allowed), `PS_OFF` (powered down) and `PS_RELOCK` (oscillator and PLLs re-enabled, outputs still parked for `RELOCK_CYC` reference cycles).

The transitions are:
- run-to-off when a synchronised power-down is seen;
- off-to-relock when it is released;
- relock-to-run when the count expires;
- relock-to-off if power-down returns during the count.

The stop pins count only while the mode strap is low; with the strap high they are ignored. Per-output enable bits from a configuration register park single outputs independently of the requests.

Top module: `pm_clk_stop`

## Requirements
- R1: While reset is asserted every clock output is low and `osc_en_o`, `pll_en_o` are 1; after release, enabled outputs start toggling within two falling edges of their clock.
- R2: With `mode_i`=0 and `cpu_stop_n_i`=0, all processor outputs are low while every other group keeps toggling.
- R3: With `mode_i`=0 and `pci_stop_n_i`=0, all ordinary PCI outputs are low while the free-running PCI and AGP outputs keep toggling.
- R4: With `mode_i`=0 and `pwr_dwn_n_i`=0, every output of every group is low regardless of the other requests, and `osc_en_o`=`pll_en_o`=0.
- R5: With `mode_i`=1, the three request pins have no effect: all enabled outputs toggle and `osc_en_o`=`pll_en_o`=1.
- R6: An enable bit of 0 (bit i of a group's enable vector controls output bit i of that group) parks that output low; outputs whose bit is 1 keep toggling.
- R7: A gate changes only while its clock is low, so every output high phase has the full width of the input high phase.
- R8: A request change sampled before a falling edge is applied at the second falling edge of the target clock: the next high phase is unchanged, and the one after it shows the new state.
- R9: After power-down is released, outputs stay low for at least `RELOCK_CYC` reference cycles while `osc_en_o` and `pll_en_o` are already 1, then resume.
- R10: A power-down that returns during the relock wait sends the block straight back to the powered-down state (`osc_en_o`=0), and a later release runs a fresh relock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Strap: 0 = request pins active, 1 = ignored |
| cpu_stop_n_i | input | 1 | Active-low processor clock stop request |
| pci_stop_n_i | input | 1 | Active-low PCI clock stop request |
| pwr_dwn_n_i | input | 1 | Active-low power-down request |
| cpu_clk_i | input | 1 | Running processor clock |
| pci_clk_i | input | 1 | Running PCI clock (also feeds the free-running output) |
| agp_clk_i | input | 1 | Running AGP clock |
| sdr_clk_i | input | 1 | Running SDRAM clock |
| usb_clk_i | input | 1 | Running USB clock |
| ref_clk_i | input | 1 | Running reference clock; also clocks the sequencer |
| cpu_en_i | input | N_CPU | Per-output enables, processor group |
| pci_en_i | input | N_PCI | Per-output enables, PCI group |
| pcif_en_i | input | 1 | Enable, free-running PCI output |
| agp_en_i | input | N_AGP | Per-output enables, AGP group |
| sdr_en_i | input | N_SDR | Per-output enables, SDRAM group |
| usb_en_i | input | 1 | Enable, USB output |
| ref_en_i | input | 1 | Enable, reference output |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock |
| agp_clk_o | output | N_AGP | Gated AGP clocks |
| sdr_clk_o | output | N_SDR | Gated SDRAM clocks |
| usb_clk_o | output | 1 | Gated USB clock |
| ref_clk_o | output | 1 | Gated reference clock |
| osc_en_o | output | 1 | Oscillator enable (0 only when powered down) |
| pll_en_o | output | 1 | PLL enable (0 only when powered down) |

## Verification
A sequencer stuck in the wrong state shows at the ports within three reference cycles. A stuck `PS_RUN` leaves outputs toggling under power-down with `osc_en_o` still 1. A stuck `PS_OFF` or `PS_RELOCK` keeps every output parked long after the release, or shows the enables at 0 in the wrong place. A relock counter that is off by one moves the restart by whole reference periods. The bench catches this by sampling on both sides of the wait.

A synchroniser with the wrong stage count or edge shows up as a request applied one high phase early or late. A gate that updates on the rising edge shows up as a high phase whose level differs between its start and its end.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // Sequencer states for the power-down / relock flow.
    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_OFF    = 2'd1,
        PS_RELOCK = 2'd2
    } pwr_state_t;

    // Depth of every request synchroniser.
    localparam int SYNC_DEPTH = 2;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter bit FALL   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    if (FALL) begin : g_fall
        // Falling-edge chain: its last stage may only move while clk is low.
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
                stg[0] <= d;
                for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
        end
    end else begin : g_rise
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
                stg[0] <= d;
                for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] want,
    output logic [W-1:0] clk_o,
    output logic [W-1:0] gate_o
);

    // The synchroniser's last stage is the gate itself.
    pm_sync #(
        .W      (W),
        .STAGES (STAGES),
        .FALL   (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (want),
        .q     (gate_o)
    );

    assign clk_o = gate_o & {W{clk}};

endmodule

// File: rtl/pm_power_seq.sv
module pm_power_seq
    import pm_pkg::*;
#(
    parameter int RELOCK_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_raw,
    output logic run_o,
    output logic osc_en_o,
    output logic pll_en_o
);

    localparam int CW = $clog2(RELOCK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RELOCK_CYC - 1);

    pwr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          pd_req;
    logic          relock_done;

    pm_sync #(
        .W      (1),
        .STAGES (SYNC_DEPTH),
        .FALL   (1'b0)
    ) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_raw),
        .q     (pd_req)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // Relock wait counter, cleared outside the wait.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q != PS_RELOCK) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    assign relock_done = (cnt_q == LAST);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:    if (pd_req) state_d = PS_OFF;
            PS_OFF:    if (!pd_req) state_d = PS_RELOCK;
            PS_RELOCK: begin
                if (pd_req)           state_d = PS_OFF;
                else if (relock_done) state_d = PS_RUN;
            end
            default:   state_d = PS_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        run_o    = 1'b0;
        osc_en_o = 1'b1;
        pll_en_o = 1'b1;
        unique case (state_q)
            PS_RUN:    run_o = 1'b1;
            PS_OFF: begin
                osc_en_o = 1'b0;
                pll_en_o = 1'b0;
            end
            PS_RELOCK: run_o = 1'b0;
            default: begin
                osc_en_o = 1'b0;
                pll_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pm_clk_stop.sv
module pm_clk_stop
    import pm_pkg::*;
#(
    parameter int N_CPU      = 4,
    parameter int N_PCI      = 6,
    parameter int N_AGP      = 2,
    parameter int N_SDR      = 12,
    parameter int RELOCK_CYC = 1024
) (
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             cpu_stop_n_i,
    input  logic             pci_stop_n_i,
    input  logic             pwr_dwn_n_i,
    input  logic             cpu_clk_i,
    input  logic             pci_clk_i,
    input  logic             agp_clk_i,
    input  logic             sdr_clk_i,
    input  logic             usb_clk_i,
    input  logic             ref_clk_i,
    input  logic [N_CPU-1:0] cpu_en_i,
    input  logic [N_PCI-1:0] pci_en_i,
    input  logic             pcif_en_i,
    input  logic [N_AGP-1:0] agp_en_i,
    input  logic [N_SDR-1:0] sdr_en_i,
    input  logic             usb_en_i,
    input  logic             ref_en_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pcif_clk_o,
    output logic [N_AGP-1:0] agp_clk_o,
    output logic [N_SDR-1:0] sdr_clk_o,
    output logic             usb_clk_o,
    output logic             ref_clk_o,
    output logic             osc_en_o,
    output logic             pll_en_o
);

    // Requests qualified by the strap (pins are active low).
    logic cpu_hold, pci_hold, pd_raw;
    logic seq_run;

    assign cpu_hold = ~mode_i & ~cpu_stop_n_i;
    assign pci_hold = ~mode_i & ~pci_stop_n_i;
    assign pd_raw   = ~mode_i & ~pwr_dwn_n_i;

    pm_power_seq #(
        .RELOCK_CYC (RELOCK_CYC)
    ) u_seq (
        .clk      (ref_clk_i),
        .rst_n    (rst_n),
        .pd_raw   (pd_raw),
        .run_o    (seq_run),
        .osc_en_o (osc_en_o),
        .pll_en_o (pll_en_o)
    );

    // Desired gate state per output, before synchronisation.
    logic [N_CPU-1:0] cpu_want, cpu_gate;
    logic [N_PCI-1:0] pci_want, pci_gate;
    logic [N_AGP-1:0] agp_want, agp_gate;
    logic [N_SDR-1:0] sdr_want, sdr_gate;
    logic             pcif_want, pcif_gate;
    logic             usb_want, usb_gate;
    logic             ref_want, ref_gate;

    assign cpu_want  = cpu_en_i & {N_CPU{seq_run & ~cpu_hold}};
    assign pci_want  = pci_en_i & {N_PCI{seq_run & ~pci_hold}};
    assign pcif_want = pcif_en_i & seq_run;
    assign agp_want  = agp_en_i & {N_AGP{seq_run}};
    assign sdr_want  = sdr_en_i & {N_SDR{seq_run}};
    assign usb_want  = usb_en_i & seq_run;
    assign ref_want  = ref_en_i & seq_run;

    pm_clk_gate #(.W(N_CPU), .STAGES(SYNC_DEPTH)) u_g_cpu (
        .clk (cpu_clk_i), .rst_n (rst_n), .want (cpu_want),
        .clk_o (cpu_clk_o), .gate_o (cpu_gate)
    );

    pm_clk_gate #(.W(N_PCI), .STAGES(SYNC_DEPTH)) u_g_pci (
        .clk (pci_clk_i), .rst_n (rst_n), .want (pci_want),
        .clk_o (pci_clk_o), .gate_o (pci_gate)
    );

    pm_clk_gate #(.W(1), .STAGES(SYNC_DEPTH)) u_g_pcif (
        .clk (pci_clk_i), .rst_n (rst_n), .want (pcif_want),
        .clk_o (pcif_clk_o), .gate_o (pcif_gate)
    );

    pm_clk_gate #(.W(N_AGP), .STAGES(SYNC_DEPTH)) u_g_agp (
        .clk (agp_clk_i), .rst_n (rst_n), .want (agp_want),
        .clk_o (agp_clk_o), .gate_o (agp_gate)
    );

    pm_clk_gate #(.W(N_SDR), .STAGES(SYNC_DEPTH)) u_g_sdr (
        .clk (sdr_clk_i), .rst_n (rst_n), .want (sdr_want),
        .clk_o (sdr_clk_o), .gate_o (sdr_gate)
    );

    pm_clk_gate #(.W(1), .STAGES(SYNC_DEPTH)) u_g_usb (
        .clk (usb_clk_i), .rst_n (rst_n), .want (usb_want),
        .clk_o (usb_clk_o), .gate_o (usb_gate)
    );

    pm_clk_gate #(.W(1), .STAGES(SYNC_DEPTH)) u_g_ref (
        .clk (ref_clk_i), .rst_n (rst_n), .want (ref_want),
        .clk_o (ref_clk_o), .gate_o (ref_gate)
    );

endmodule

// File: rtl/pm_clk_stop_checks.sv
module pm_clk_stop_checks #(
    parameter int N_CPU = 4,
    parameter int N_PCI = 6
) (
    input logic             rst_n,
    input logic             mode_i,
    input logic             cpu_stop_n_i,
    input logic             pci_stop_n_i,
    input logic             pwr_dwn_n_i,
    input logic             cpu_clk_i,
    input logic             pci_clk_i,
    input logic             ref_clk_i,
    input logic             osc_en_o,
    input logic             pll_en_o,
    input logic             seq_run,
    input logic [N_CPU-1:0] cpu_gate,
    input logic [N_PCI-1:0] pci_gate,
    input logic             ref_gate
);

    // R2: a processor stop held over three samples has closed the gate.
    a_r2_cpu_stop_closes: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
        (!mode_i && !cpu_stop_n_i && $past(!mode_i && !cpu_stop_n_i)
         && $past(!mode_i && !cpu_stop_n_i, 2)) |-> (cpu_gate == '0));

    // R3: a PCI stop held over three samples has closed the PCI gates.
    a_r3_pci_stop_closes: assert property (@(posedge pci_clk_i) disable iff (!rst_n)
        (!mode_i && !pci_stop_n_i && $past(!mode_i && !pci_stop_n_i)
         && $past(!mode_i && !pci_stop_n_i, 2)) |-> (pci_gate == '0));

    // R4: once PLLs are off for three samples the processor gate is shut.
    a_r4_pd_closes_cpu: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
        (!pll_en_o && $past(!pll_en_o) && $past(!pll_en_o, 2)) |-> (cpu_gate == '0));

    // R4: a power-down pin held four samples has turned the PLLs off.
    a_r4_pd_stops_pll: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (!mode_i && !pwr_dwn_n_i && $past(!mode_i && !pwr_dwn_n_i)
         && $past(!mode_i && !pwr_dwn_n_i, 2) && $past(!mode_i && !pwr_dwn_n_i, 3))
        |-> !pll_en_o);

    // R5: with the strap high for five samples the PLLs are on.
    a_r5_mode_high_keeps_power: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (mode_i && $past(mode_i) && $past(mode_i, 2) && $past(mode_i, 3) && $past(mode_i, 4))
        |-> (pll_en_o && osc_en_o));

    // R9: outside the run state, the reference gate closes after two samples.
    a_r9_wait_keeps_ref_low: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (!seq_run && $past(!seq_run) && $past(!seq_run, 2)) |-> (ref_gate == 1'b0));

    // R7: gates never move during a high phase of their clock.
    always @(cpu_gate) begin
        if (rst_n) begin
            a_r7_cpu_gate_low_phase: assert (!cpu_clk_i);
        end
    end

    always @(pci_gate) begin
        if (rst_n) begin
            a_r7_pci_gate_low_phase: assert (!pci_clk_i);
        end
    end

    always @(ref_gate) begin
        if (rst_n) begin
            a_r7_ref_gate_low_phase: assert (!ref_clk_i);
        end
    end

endmodule

bind pm_clk_stop pm_clk_stop_checks #(
    .N_CPU (N_CPU),
    .N_PCI (N_PCI)
) u_checks (
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .cpu_stop_n_i (cpu_stop_n_i),
    .pci_stop_n_i (pci_stop_n_i),
    .pwr_dwn_n_i  (pwr_dwn_n_i),
    .cpu_clk_i    (cpu_clk_i),
    .pci_clk_i    (pci_clk_i),
    .ref_clk_i    (ref_clk_i),
    .osc_en_o     (osc_en_o),
    .pll_en_o     (pll_en_o),
    .seq_run      (seq_run),
    .cpu_gate     (cpu_gate),
    .pci_gate     (pci_gate),
    .ref_gate     (ref_gate)
);

// File: tb/pm_clk_stop_test.sv
module pm_clk_stop_test;

    localparam int N_CPU  = 4;
    localparam int N_PCI  = 6;
    localparam int N_AGP  = 2;
    localparam int N_SDR  = 12;
    localparam int RELOCK = 20;
    localparam int NVEC   = 6;

    // [9] mode [8] cpu_stop_n [7] pci_stop_n [6] pwr_dwn_n
    // expected toggling: [5] cpu [4] pci [3] pcif [2] agp [1] sdram [0] usb+ref
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0_1_1_1_111111,
        10'b0_0_1_1_011111,
        10'b0_1_0_1_101111,
        10'b0_0_0_1_001111,
        10'b1_0_0_0_111111,
        10'b0_0_1_0_000000
    };
    // Requirement tag per vector: 2,2,3,3,5,4
    localparam int VTAG [NVEC] = '{2, 2, 3, 3, 5, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, cs_n = 1'b1, ps_n = 1'b1, pd_n = 1'b1;
    logic [N_CPU-1:0] cpu_en = '1;
    logic [N_PCI-1:0] pci_en = '1;
    logic [N_AGP-1:0] agp_en = '1;
    logic [N_SDR-1:0] sdr_en = '1;
    logic pcif_en = 1'b1, usb_en = 1'b1, ref_en = 1'b1;

    logic [N_CPU-1:0] cpu_o;
    logic [N_PCI-1:0] pci_o;
    logic [N_AGP-1:0] agp_o;
    logic [N_SDR-1:0] sdr_o;
    logic pcif_o, usb_o, ref_o, osc_en, pll_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pm_clk_stop #(
        .N_CPU (N_CPU), .N_PCI (N_PCI), .N_AGP (N_AGP), .N_SDR (N_SDR),
        .RELOCK_CYC (RELOCK)
    ) uut (
        .rst_n (rst_n), .mode_i (mode), .cpu_stop_n_i (cs_n),
        .pci_stop_n_i (ps_n), .pwr_dwn_n_i (pd_n),
        .cpu_clk_i (clk), .pci_clk_i (clk), .agp_clk_i (clk),
        .sdr_clk_i (clk), .usb_clk_i (clk), .ref_clk_i (clk),
        .cpu_en_i (cpu_en), .pci_en_i (pci_en), .pcif_en_i (pcif_en),
        .agp_en_i (agp_en), .sdr_en_i (sdr_en), .usb_en_i (usb_en),
        .ref_en_i (ref_en),
        .cpu_clk_o (cpu_o), .pci_clk_o (pci_o), .pcif_clk_o (pcif_o),
        .agp_clk_o (agp_o), .sdr_clk_o (sdr_o), .usb_clk_o (usb_o),
        .ref_clk_o (ref_o), .osc_en_o (osc_en), .pll_en_o (pll_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Return to posedge + 2 ns, in the middle of a high phase.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic string tagname(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(2);
        chk("R1 cpu in reset", 32'(cpu_o), 0);
        chk("R1 sdram in reset", 32'(sdr_o), 0);
        chk("R1 ref in reset", 32'(ref_o), 0);
        chk("R1 enables in reset", {30'd0, osc_en, pll_en}, 32'd3);
        rst_n = 1'b1;
        tick(3);
        chk("R1 cpu after reset", 32'(cpu_o), 32'hF);
        chk("R1 ref after reset", 32'(ref_o), 32'h1);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            mode = VEC[v][9];
            cs_n = VEC[v][8];
            ps_n = VEC[v][7];
            pd_n = VEC[v][6];
            tick(8);
            chk(tagname(VTAG[v]), 32'(cpu_o),  VEC[v][5] ? 32'hF : 0);
            chk(tagname(VTAG[v]), 32'(pci_o),  VEC[v][4] ? 32'h3F : 0);
            chk(tagname(VTAG[v]), 32'(pcif_o), VEC[v][3] ? 32'h1 : 0);
            chk(tagname(VTAG[v]), 32'(agp_o),  VEC[v][2] ? 32'h3 : 0);
            chk(tagname(VTAG[v]), 32'(sdr_o),  VEC[v][1] ? 32'hFFF : 0);
            chk(tagname(VTAG[v]), {30'd0, usb_o, ref_o}, VEC[v][0] ? 32'h3 : 0);
        end
        chk("R4 osc/pll off", {30'd0, osc_en, pll_en}, 32'd0);

        // R9: release power-down, wait through relock
        cs_n = 1'b1;
        pd_n = 1'b1;
        tick(RELOCK);
        chk("R9 ref parked in wait", 32'(ref_o), 0);
        chk("R9 cpu parked in wait", 32'(cpu_o), 0);
        chk("R9 osc/pll on in wait", {30'd0, osc_en, pll_en}, 32'd3);
        tick(8);
        chk("R9 ref resumed", 32'(ref_o), 32'h1);
        chk("R9 sdram resumed", 32'(sdr_o), 32'hFFF);

        // R10: power-down returns during the wait
        pd_n = 1'b0;
        tick(8);
        pd_n = 1'b1;
        tick(6);
        chk("R10 in wait", {30'd0, osc_en, pll_en}, 32'd3);
        pd_n = 1'b0;
        tick(6);
        chk("R10 back off", {30'd0, osc_en, pll_en}, 32'd0);
        chk("R10 cpu parked", 32'(cpu_o), 0);
        pd_n = 1'b1;
        tick(RELOCK);
        chk("R10 fresh wait still parked", 32'(ref_o), 0);
        tick(8);
        chk("R10 resumed", 32'(cpu_o), 32'hF);

        // R6: enable bits
        cpu_en = 4'b1010;
        sdr_en = 12'h0F3;
        pcif_en = 1'b0;
        tick(4);
        chk("R6 cpu pattern", 32'(cpu_o), 32'hA);
        chk("R6 sdram pattern", 32'(sdr_o), 32'h0F3);
        chk("R6 pcif parked", 32'(pcif_o), 0);
        chk("R6 pci untouched", 32'(pci_o), 32'h3F);
        cpu_en = '1;
        sdr_en = '1;
        pcif_en = 1'b1;
        tick(4);

        // R8: stop applied at second falling edge
        cs_n = 1'b0;
        tick(1);
        chk("R8 next phase unchanged", 32'(cpu_o), 32'hF);
        tick(1);
        chk("R8 following phase stopped", 32'(cpu_o), 0);
        cs_n = 1'b1;
        tick(1);
        chk("R8 release next phase low", 32'(cpu_o), 0);
        tick(1);
        chk("R8 release following phase high", 32'(cpu_o), 32'hF);

        // R7: each high phase is whole across a stop/start sequence
        cs_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            logic [N_CPU-1:0] early, late;
            if (k == 3) cs_n = 1'b1;
            @(posedge clk);
            #1 early = cpu_o;
            #2 late = cpu_o;
            chk("R7 full-width phase", 32'(late), 32'(early));
        end
        tick(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule